// File: doc/BRIEF.md
# Suspendable Flash Operation Sequencer

This block sequences the long-running operations of a behavioural flash array. A host hands it already-decoded requests to erase a single block, erase every block, program one word, or rewrite one block's lock configuration. Each accepted request becomes a busy phase, and a cycle counter stands in for the real program or erase time. When the phase ends, the block issues a one-cycle strobe to the array model together with the target address.

The host may pause a running block erase. While the erase is paused, the host can read any other block or program a word in any other block. A program may itself be paused so that other locations can be read. This holds when the program was started inside a paused erase, which gives two levels of suspension. The block models a ready/busy pin as an open-drain pull-down enable. It reports ready, erase-paused, program-paused and error flags, and gives a one-cycle pulse when an operation completes. Reset is asserted asynchronously, released through a two-stage synchronizer, and aborts whatever was running.

Top module: `flash_op_seq`

## Requirements
- R1: A program request (`req_op`=2) runs for T_PROG cycles and then pulses `arr_wr` with the requested block and offset. A lock-configuration request (`req_op`=3) runs for T_LOCK cycles and then pulses `arr_lock` with the requested block and offset 0.
- R2: A block erase (`req_op`=0) runs for T_ERASE_SMALL cycles on the SMALL_BLKS highest-numbered blocks and for T_ERASE_BIG cycles on every other block, then pulses `arr_erase` with that block. A full erase (`req_op`=1) runs for T_CHIP cycles and then pulses `arr_erase` and `arr_erase_all` together, with block 0.
- R3: `rb_low` is 1 in exactly those cycles in which an erase, program or lock operation is running, and `sr_ready` is 0 in the same cycles.
- R4: `rb_low` is 0 (pin floating) when the block is idle, when an erase is paused with no program running, when a program is paused, and while reset is held.
- R5: While reset is held, `sr_ready`, `sr_erase_susp` and `sr_prog_susp` are all 0. `sr_ready` becomes 1 on the third rising clock edge after `rst_n` rises.
- R6: `susp_req` during a block erase pauses it and sets `sr_erase_susp`. `resume_req` continues the erase from the remaining count, so the busy cycles before and after the pause add up to the full erase time.
- R7: During an erase pause, a program to another block runs while `sr_erase_susp` stays 1. `susp_req` pauses that program and sets `sr_prog_susp`. `resume_req` then continues the program from where it stopped, and when the program completes the block returns to the erase pause.
- R8: During an erase pause, a read or program aimed at the paused block is rejected: no strobe is issued and `sr_err` goes to 1. During a program pause, a read of the word being programmed is rejected in the same way. Reads of other locations pulse `arr_rd` with the read address one cycle later.
- R9: While an operation runs, new operation requests and reads are ignored, and `susp_req` is the only input that has an effect. A full erase and a lock operation cannot be paused.
- R10: Reset aborts a running or paused operation, clears the paused flags, and produces no completion strobe for the aborted operation afterwards.
- R11: `op_done` is 1 for exactly one cycle, the same cycle as the completion strobe of the operation.
- R12: `sr_err` stays 1 until the next accepted operation request or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 block erase, 1 full erase, 2 program, 3 lock configuration |
| req_blk | input | BLK_W (3) | Target block |
| req_off | input | OFF_W (4) | Target word offset (program only) |
| susp_req | input | 1 | Pause the running operation |
| resume_req | input | 1 | Continue the innermost paused operation |
| rd_req | input | 1 | Array read request |
| rd_blk | input | BLK_W (3) | Read block |
| rd_off | input | OFF_W (4) | Read word offset |
| rb_low | output | 1 | Ready/busy pull-down enable (1 = driven low, 0 = floating) |
| sr_ready | output | 1 | Status: no operation running |
| sr_erase_susp | output | 1 | Status: an erase is paused |
| sr_prog_susp | output | 1 | Status: a program is paused |
| sr_err | output | 1 | Status: a request was rejected |
| op_done | output | 1 | Completion pulse |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array word write strobe |
| arr_erase | output | 1 | Array erase strobe |
| arr_erase_all | output | 1 | Qualifies `arr_erase` as a full-array erase |
| arr_lock | output | 1 | Lock configuration write strobe |
| arr_blk | output | BLK_W (3) | Block address for the strobes |
| arr_off | output | OFF_W (4) | Word offset for the strobes |

## Verification
The four operation kinds are each run alone, and erases are aimed at both a large and a small block. Comparing the busy lengths shows whether the duration is chosen from the block class or fixed. Pause and resume are exercised at one and at two levels of nesting, with the busy cycles counted across each pause. A counter that keeps running while paused gives a total that is too short, and one that reloads on resume gives a total that is too long. Reads and programs are then aimed at the paused block, at the paused word, and at unrelated locations. These patterns separate correct rejection from over-blocking. Further runs send requests while busy, send a pause to operations that cannot be paused, and apply reset during a pause, which shows whether the block ignores, refuses and aborts where it should.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_BLK_ERASE  = 2'd0,
    OP_CHIP_ERASE = 2'd1,
    OP_PROGRAM    = 2'd2,
    OP_LOCKCFG    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ERASE,
    S_CHIP,
    S_PROG,
    S_LOCK,
    S_ESUSP,
    S_PROG_ES,
    S_PSUSP,
    S_PSUSP_ES
  } seq_state_e;

  function automatic logic is_running(input seq_state_e s);
    return (s == S_ERASE) || (s == S_CHIP) || (s == S_PROG) ||
           (s == S_LOCK)  || (s == S_PROG_ES);
  endfunction

  function automatic logic erase_held(input seq_state_e s);
    return (s == S_ESUSP) || (s == S_PROG_ES) || (s == S_PSUSP_ES);
  endfunction

  function automatic logic prog_held(input seq_state_e s);
    return (s == S_PSUSP) || (s == S_PSUSP_ES);
  endfunction

endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire,
  output logic [CNT_W-1:0] remain
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign expire = run && (cnt_q == CNT_W'(1));
  assign remain = cnt_q;

  // R1: the controller never loads a duration too short to be observed
  a_r1_load_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val > CNT_W'(1)));

  // R3: a running phase always has time left on its counter
  a_r3_run_has_time: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int NUM_BLK       = 8,
  parameter int SMALL_BLKS    = 2,
  parameter int BLK_W         = 3,
  parameter int OFF_W         = 4,
  parameter int CNT_W         = 8,
  parameter int T_ERASE_BIG   = 30,
  parameter int T_ERASE_SMALL = 12,
  parameter int T_CHIP        = 50,
  parameter int T_PROG        = 6,
  parameter int T_LOCK        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  op_e              req_op,
  input  logic [BLK_W-1:0] req_blk,
  input  logic [OFF_W-1:0] req_off,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             rd_req,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [OFF_W-1:0] rd_off,
  input  logic             er_exp,
  input  logic [CNT_W-1:0] er_remain,
  input  logic             pg_exp,
  input  logic [CNT_W-1:0] pg_remain,
  output logic             er_load,
  output logic [CNT_W-1:0] er_val,
  output logic             er_run,
  output logic             pg_load,
  output logic [CNT_W-1:0] pg_val,
  output logic             pg_run,
  output logic             rb_low,
  output logic             sr_ready,
  output logic             sr_erase_susp,
  output logic             sr_prog_susp,
  output logic             sr_err,
  output logic             op_done,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic             arr_erase,
  output logic             arr_erase_all,
  output logic             arr_lock,
  output logic [BLK_W-1:0] arr_blk,
  output logic [OFF_W-1:0] arr_off
);

  localparam logic [BLK_W-1:0] FIRST_SMALL = BLK_W'(NUM_BLK - SMALL_BLKS);

  seq_state_e       state_q, state_nxt;
  logic [BLK_W-1:0] eblk_q, eblk_nxt;
  logic [BLK_W-1:0] pblk_q, pblk_nxt;
  logic [OFF_W-1:0] poff_q, poff_nxt;
  logic             err_q, err_nxt;
  logic             ready_q, esusp_q, psusp_q, rb_q, done_q;
  logic             rd_q, wr_q, er_q, all_q, lk_q;
  logic [BLK_W-1:0] ablk_q, ablk_nxt;
  logic [OFF_W-1:0] aoff_q, aoff_nxt;

  logic acc_op, rd_ok, rejected;
  logic fin_erase, fin_chip, fin_prog, fin_lock;
  logic prog_same_word;

  function automatic logic [CNT_W-1:0] erase_time(input logic [BLK_W-1:0] b);
    return (b >= FIRST_SMALL) ? CNT_W'(T_ERASE_SMALL) : CNT_W'(T_ERASE_BIG);
  endfunction

  assign er_run = (state_q == S_ERASE) || (state_q == S_CHIP);
  assign pg_run = (state_q == S_PROG) || (state_q == S_PROG_ES) || (state_q == S_LOCK);
  assign prog_same_word = (rd_blk == pblk_q) && (rd_off == poff_q);

  // next-state logic
  always_comb begin
    state_nxt = state_q;
    eblk_nxt  = eblk_q;
    pblk_nxt  = pblk_q;
    poff_nxt  = poff_q;
    er_load   = 1'b0;
    er_val    = '0;
    pg_load   = 1'b0;
    pg_val    = '0;
    acc_op    = 1'b0;
    rd_ok     = 1'b0;
    rejected  = 1'b0;
    fin_erase = 1'b0;
    fin_chip  = 1'b0;
    fin_prog  = 1'b0;
    fin_lock  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          acc_op = 1'b1;
          unique case (req_op)
            OP_BLK_ERASE: begin
              state_nxt = S_ERASE;
              er_load   = 1'b1;
              er_val    = erase_time(req_blk);
              eblk_nxt  = req_blk;
            end
            OP_CHIP_ERASE: begin
              state_nxt = S_CHIP;
              er_load   = 1'b1;
              er_val    = CNT_W'(T_CHIP);
              eblk_nxt  = '0;
            end
            OP_PROGRAM: begin
              state_nxt = S_PROG;
              pg_load   = 1'b1;
              pg_val    = CNT_W'(T_PROG);
              pblk_nxt  = req_blk;
              poff_nxt  = req_off;
            end
            default: begin
              state_nxt = S_LOCK;
              pg_load   = 1'b1;
              pg_val    = CNT_W'(T_LOCK);
              pblk_nxt  = req_blk;
              poff_nxt  = '0;
            end
          endcase
        end else if (rd_req) begin
          rd_ok = 1'b1;
        end
      end
      S_ERASE: begin
        if (er_exp) begin
          state_nxt = S_IDLE;
          fin_erase = 1'b1;
        end else if (susp_req) begin
          state_nxt = S_ESUSP;
        end
      end
      S_CHIP: begin
        if (er_exp) begin
          state_nxt = S_IDLE;
          fin_chip  = 1'b1;
        end
      end
      S_PROG: begin
        if (pg_exp) begin
          state_nxt = S_IDLE;
          fin_prog  = 1'b1;
        end else if (susp_req) begin
          state_nxt = S_PSUSP;
        end
      end
      S_LOCK: begin
        if (pg_exp) begin
          state_nxt = S_IDLE;
          fin_lock  = 1'b1;
        end
      end
      S_ESUSP: begin
        if (resume_req) begin
          state_nxt = S_ERASE;
        end else if (req_valid && (req_op == OP_PROGRAM)) begin
          if (req_blk == eblk_q) begin
            rejected = 1'b1;
          end else begin
            acc_op    = 1'b1;
            state_nxt = S_PROG_ES;
            pg_load   = 1'b1;
            pg_val    = CNT_W'(T_PROG);
            pblk_nxt  = req_blk;
            poff_nxt  = req_off;
          end
        end else if (rd_req) begin
          rejected = (rd_blk == eblk_q);
          rd_ok    = (rd_blk != eblk_q);
        end
      end
      S_PROG_ES: begin
        if (pg_exp) begin
          state_nxt = S_ESUSP;
          fin_prog  = 1'b1;
        end else if (susp_req) begin
          state_nxt = S_PSUSP_ES;
        end
      end
      S_PSUSP: begin
        if (resume_req) begin
          state_nxt = S_PROG;
        end else if (rd_req) begin
          rejected = prog_same_word;
          rd_ok    = !prog_same_word;
        end
      end
      S_PSUSP_ES: begin
        if (resume_req) begin
          state_nxt = S_PROG_ES;
        end else if (rd_req) begin
          rejected = prog_same_word || (rd_blk == eblk_q);
          rd_ok    = !(prog_same_word || (rd_blk == eblk_q));
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  // error flag and strobe address
  always_comb begin
    err_nxt = err_q;
    if (acc_op) begin
      err_nxt = 1'b0;
    end else if (rejected) begin
      err_nxt = 1'b1;
    end
    if (rd_ok) begin
      ablk_nxt = rd_blk;
      aoff_nxt = rd_off;
    end else if (fin_prog || fin_lock || pg_load || prog_held(state_nxt) ||
                 (state_nxt == S_PROG) || (state_nxt == S_PROG_ES) || (state_nxt == S_LOCK)) begin
      ablk_nxt = pblk_nxt;
      aoff_nxt = poff_nxt;
    end else begin
      ablk_nxt = eblk_nxt;
      aoff_nxt = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      eblk_q  <= '0;
      pblk_q  <= '0;
      poff_q  <= '0;
      err_q   <= 1'b0;
      ready_q <= 1'b0;
      esusp_q <= 1'b0;
      psusp_q <= 1'b0;
      rb_q    <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      er_q    <= 1'b0;
      all_q   <= 1'b0;
      lk_q    <= 1'b0;
      ablk_q  <= '0;
      aoff_q  <= '0;
    end else begin
      state_q <= state_nxt;
      eblk_q  <= eblk_nxt;
      pblk_q  <= pblk_nxt;
      poff_q  <= poff_nxt;
      err_q   <= err_nxt;
      ready_q <= !is_running(state_nxt);
      esusp_q <= erase_held(state_nxt);
      psusp_q <= prog_held(state_nxt);
      rb_q    <= is_running(state_nxt);
      done_q  <= fin_erase || fin_chip || fin_prog || fin_lock;
      rd_q    <= rd_ok;
      wr_q    <= fin_prog;
      er_q    <= fin_erase || fin_chip;
      all_q   <= fin_chip;
      lk_q    <= fin_lock;
      ablk_q  <= ablk_nxt;
      aoff_q  <= aoff_nxt;
    end
  end

  assign rb_low        = rb_q;
  assign sr_ready      = ready_q;
  assign sr_erase_susp = esusp_q;
  assign sr_prog_susp  = psusp_q;
  assign sr_err        = err_q;
  assign op_done       = done_q;
  assign arr_rd        = rd_q;
  assign arr_wr        = wr_q;
  assign arr_erase     = er_q;
  assign arr_erase_all = all_q;
  assign arr_lock      = lk_q;
  assign arr_blk       = ablk_q;
  assign arr_off       = aoff_q;

  // R4: pin floats whenever a program is paused
  a_r4_float_prog_paused: assert property (@(posedge clk) disable iff (!rst_n)
    sr_prog_susp |-> !rb_low);

  // R6: the erase counter does not move while the erase is held
  a_r6_erase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_held(state_q) && $past(erase_held(state_q))) |-> (er_remain == $past(er_remain)));

  // R7: the program counter does not move while the program is held
  a_r7_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_held(state_q) && $past(prog_held(state_q))) |-> (pg_remain == $past(pg_remain)));

  // R8: no read strobe ever targets the block whose erase is paused
  a_r8_no_read_paused_blk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && sr_erase_susp) |-> (arr_blk != eblk_q));

  // R11: completion pulse lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R3: busy pin implies a counter with time left
  a_r3_busy_has_time: assert property (@(posedge clk) disable iff (!rst_n)
    rb_low |-> ((er_remain != '0) || (pg_remain != '0)));

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import fseq_pkg::*;
#(
  parameter int NUM_BLK       = 8,
  parameter int SMALL_BLKS    = 2,
  parameter int OFF_W         = 4,
  parameter int T_ERASE_BIG   = 30,
  parameter int T_ERASE_SMALL = 12,
  parameter int T_CHIP        = 50,
  parameter int T_PROG        = 6,
  parameter int T_LOCK        = 4,
  localparam int BLK_W        = $clog2(NUM_BLK),
  localparam int T_MAX        = (T_CHIP > T_ERASE_BIG) ? T_CHIP : T_ERASE_BIG,
  localparam int CNT_W        = $clog2(T_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [BLK_W-1:0] req_blk,
  input  logic [OFF_W-1:0] req_off,
  input  logic             susp_req,
  input  logic             resume_req,
  input  logic             rd_req,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [OFF_W-1:0] rd_off,
  output logic             rb_low,
  output logic             sr_ready,
  output logic             sr_erase_susp,
  output logic             sr_prog_susp,
  output logic             sr_err,
  output logic             op_done,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic             arr_erase,
  output logic             arr_erase_all,
  output logic             arr_lock,
  output logic [BLK_W-1:0] arr_blk,
  output logic [OFF_W-1:0] arr_off
);

  logic             rst_s_n;
  logic             er_load, er_run, er_exp;
  logic             pg_load, pg_run, pg_exp;
  logic [CNT_W-1:0] er_val, er_remain, pg_val, pg_remain;

  fseq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  fseq_timer #(.CNT_W(CNT_W)) u_er_tmr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (er_load),
    .load_val (er_val),
    .run      (er_run),
    .expire   (er_exp),
    .remain   (er_remain)
  );

  fseq_timer #(.CNT_W(CNT_W)) u_pg_tmr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (pg_load),
    .load_val (pg_val),
    .run      (pg_run),
    .expire   (pg_exp),
    .remain   (pg_remain)
  );

  fseq_ctrl #(
    .NUM_BLK       (NUM_BLK),
    .SMALL_BLKS    (SMALL_BLKS),
    .BLK_W         (BLK_W),
    .OFF_W         (OFF_W),
    .CNT_W         (CNT_W),
    .T_ERASE_BIG   (T_ERASE_BIG),
    .T_ERASE_SMALL (T_ERASE_SMALL),
    .T_CHIP        (T_CHIP),
    .T_PROG        (T_PROG),
    .T_LOCK        (T_LOCK)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .req_valid     (req_valid),
    .req_op        (op_e'(req_op)),
    .req_blk       (req_blk),
    .req_off       (req_off),
    .susp_req      (susp_req),
    .resume_req    (resume_req),
    .rd_req        (rd_req),
    .rd_blk        (rd_blk),
    .rd_off        (rd_off),
    .er_exp        (er_exp),
    .er_remain     (er_remain),
    .pg_exp        (pg_exp),
    .pg_remain     (pg_remain),
    .er_load       (er_load),
    .er_val        (er_val),
    .er_run        (er_run),
    .pg_load       (pg_load),
    .pg_val        (pg_val),
    .pg_run        (pg_run),
    .rb_low        (rb_low),
    .sr_ready      (sr_ready),
    .sr_erase_susp (sr_erase_susp),
    .sr_prog_susp  (sr_prog_susp),
    .sr_err        (sr_err),
    .op_done       (op_done),
    .arr_rd        (arr_rd),
    .arr_wr        (arr_wr),
    .arr_erase     (arr_erase),
    .arr_erase_all (arr_erase_all),
    .arr_lock      (arr_lock),
    .arr_blk       (arr_blk),
    .arr_off       (arr_off)
  );

  // R9: at most one array strobe per cycle
  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({arr_rd, arr_wr, arr_erase, arr_lock}));

  // R2: full-erase qualifier only accompanies an erase strobe
  a_r2_all_with_erase: assert property (@(posedge clk) disable iff (!rst_s_n)
    arr_erase_all |-> arr_erase);

endmodule

// File: tb/tb_flash_op_seq.sv
module tb_flash_op_seq;

  localparam int T_EB = 30;
  localparam int T_ES = 12;
  localparam int T_CH = 50;
  localparam int T_PG = 6;
  localparam int T_LK = 4;

  localparam logic [2:0] K_RD  = 3'd0;
  localparam logic [2:0] K_WR  = 3'd1;
  localparam logic [2:0] K_ER  = 3'd2;
  localparam logic [2:0] K_ALL = 3'd3;
  localparam logic [2:0] K_LK  = 3'd4;

  typedef struct packed {
    logic [2:0] kind;
    logic [2:0] blk;
    logic [3:0] off;
  } ev_t;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [2:0] req_blk;
  logic [3:0] req_off;
  logic       susp_req, resume_req, rd_req;
  logic [2:0] rd_blk;
  logic [3:0] rd_off;
  logic       rb_low, sr_ready, sr_erase_susp, sr_prog_susp, sr_err, op_done;
  logic       arr_rd, arr_wr, arr_erase, arr_erase_all, arr_lock;
  logic [2:0] arr_blk;
  logic [3:0] arr_off;

  ev_t exp_q[$];
  int  n_chk;
  int  n_fail;
  int  busy_n;
  int  saved_n;

  flash_op_seq #(
    .NUM_BLK(8), .SMALL_BLKS(2), .OFF_W(4),
    .T_ERASE_BIG(T_EB), .T_ERASE_SMALL(T_ES), .T_CHIP(T_CH),
    .T_PROG(T_PG), .T_LOCK(T_LK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .req_off(req_off), .susp_req(susp_req),
    .resume_req(resume_req), .rd_req(rd_req), .rd_blk(rd_blk), .rd_off(rd_off),
    .rb_low(rb_low), .sr_ready(sr_ready), .sr_erase_susp(sr_erase_susp),
    .sr_prog_susp(sr_prog_susp), .sr_err(sr_err), .op_done(op_done),
    .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_erase(arr_erase),
    .arr_erase_all(arr_erase_all), .arr_lock(arr_lock),
    .arr_blk(arr_blk), .arr_off(arr_off)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk_eq(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_ev(input logic [2:0] k, input logic [2:0] b, input logic [3:0] o);
    ev_t e;
    e.kind = k;
    e.blk  = b;
    e.off  = o;
    exp_q.push_back(e);
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] b, input logic [3:0] o);
    if (rb_low) busy_n++;
    req_valid = 1'b1;
    req_op    = op;
    req_blk   = b;
    req_off   = o;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] b, input logic [3:0] o);
    if (rb_low) busy_n++;
    rd_req = 1'b1;
    rd_blk = b;
    rd_off = o;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pause_op();
    if (rb_low) busy_n++;
    susp_req = 1'b1;
    @(negedge clk);
    susp_req = 1'b0;
  endtask

  task automatic resume_op();
    if (rb_low) busy_n++;
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
  endtask

  task automatic run_cycles(input int k);
    repeat (k) begin
      if (rb_low) busy_n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    while (rb_low) begin
      busy_n++;
      @(negedge clk);
    end
  endtask

  // monitor: pops expected strobes in order of appearance
  always @(negedge clk) begin
    ev_t ob;
    ev_t ex;
    if (arr_rd || arr_wr || arr_erase || arr_lock) begin
      ob.kind = arr_rd ? K_RD : arr_wr ? K_WR : arr_lock ? K_LK :
                arr_erase_all ? K_ALL : K_ER;
      ob.blk  = arr_blk;
      ob.off  = arr_off;
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9/R10 unexpected strobe actual=%0d expected=%0d", ob, -1);
      end else begin
        ex = exp_q.pop_front();
        chk_eq("R1/R2/R8 strobe kind+address", int'(ob), int'(ex));
      end
      if (!arr_rd) chk_eq("R11 done with completion strobe", op_done, 1);
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; busy_n = 0; saved_n = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_blk = '0; req_off = '0;
    susp_req = 1'b0; resume_req = 1'b0; rd_req = 1'b0; rd_blk = '0; rd_off = '0;
    repeat (3) @(negedge clk);
    // R5 / R4: reset state
    chk_eq("R5 ready in reset", sr_ready, 0);
    chk_eq("R5 esusp in reset", sr_erase_susp, 0);
    chk_eq("R5 psusp in reset", sr_prog_susp, 0);
    chk_eq("R4 rb floats in reset", rb_low, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_eq("R5 ready not yet after 2 edges", sr_ready, 0);
    @(negedge clk);
    chk_eq("R5 ready on 3rd edge", sr_ready, 1);

    // R8 idle read
    push_ev(K_RD, 3'd4, 4'd9);
    rd(3'd4, 4'd9);
    @(negedge clk);

    // R1 program
    push_ev(K_WR, 3'd1, 4'd3);
    busy_n = 0;
    issue(2'd2, 3'd1, 4'd3);
    chk_eq("R3 busy pin after accept", rb_low, 1);
    chk_eq("R3 ready low while busy", sr_ready, 0);
    wait_ready();
    chk_eq("R1 program duration", busy_n, T_PG);
    @(negedge clk);
    chk_eq("R11 done clears", op_done, 0);

    // R2 large block erase
    push_ev(K_ER, 3'd0, 4'd0);
    busy_n = 0;
    issue(2'd0, 3'd0, 4'd5);
    wait_ready();
    chk_eq("R2 large erase duration", busy_n, T_EB);

    // R2 small block erase
    push_ev(K_ER, 3'd7, 4'd0);
    busy_n = 0;
    issue(2'd0, 3'd7, 4'd0);
    wait_ready();
    chk_eq("R2 small erase duration", busy_n, T_ES);

    // R2 / R9 full erase, pause ignored
    push_ev(K_ALL, 3'd0, 4'd0);
    busy_n = 0;
    issue(2'd1, 3'd3, 4'd0);
    run_cycles(5);
    pause_op();
    chk_eq("R9 full erase not paused", sr_erase_susp, 0);
    wait_ready();
    chk_eq("R2 full erase duration", busy_n, T_CH);

    // R1 / R9 lock, pause ignored
    push_ev(K_LK, 3'd5, 4'd0);
    busy_n = 0;
    issue(2'd3, 3'd5, 4'd6);
    pause_op();
    chk_eq("R9 lock not paused", rb_low, 1);
    wait_ready();
    chk_eq("R1 lock duration", busy_n, T_LK);

    // R9 requests and reads while busy are ignored
    push_ev(K_WR, 3'd4, 4'd7);
    busy_n = 0;
    issue(2'd2, 3'd4, 4'd7);
    issue(2'd0, 3'd1, 4'd0);
    rd(3'd6, 4'd2);
    wait_ready();
    chk_eq("R9 busy length unchanged", busy_n, T_PG);
    chk_eq("R9 no error from ignored read", sr_err, 0);
    run_cycles(3);

    // R6 / R7 / R8 nested pause
    push_ev(K_RD, 3'd2, 4'd5);
    push_ev(K_RD, 3'd3, 4'd1);
    push_ev(K_WR, 3'd2, 4'd1);
    push_ev(K_ER, 3'd0, 4'd0);
    busy_n = 0;
    issue(2'd0, 3'd0, 4'd0);
    run_cycles(4);
    pause_op();
    saved_n = busy_n;
    chk_eq("R6 erase paused flag", sr_erase_susp, 1);
    chk_eq("R4 rb floats in erase pause", rb_low, 0);
    chk_eq("R6 ready during pause", sr_ready, 1);
    rd(3'd0, 4'd2);
    chk_eq("R8 read of paused block errors", sr_err, 1);
    issue(2'd2, 3'd0, 4'd4);
    chk_eq("R8 program of paused block refused", rb_low, 0);
    chk_eq("R12 error sticky", sr_err, 1);
    rd(3'd2, 4'd5);
    busy_n = 0;
    issue(2'd2, 3'd2, 4'd1);
    chk_eq("R12 error cleared by accepted op", sr_err, 0);
    chk_eq("R7 program runs under erase pause", rb_low, 1);
    chk_eq("R7 erase flag kept", sr_erase_susp, 1);
    run_cycles(2);
    pause_op();
    chk_eq("R7 program paused flag", sr_prog_susp, 1);
    chk_eq("R4 rb floats in program pause", rb_low, 0);
    rd(3'd2, 4'd1);
    chk_eq("R8 read of paused word errors", sr_err, 1);
    rd(3'd3, 4'd1);
    resume_op();
    wait_ready();
    chk_eq("R7 nested program total time", busy_n, T_PG);
    chk_eq("R7 back to erase pause", sr_erase_susp, 1);
    chk_eq("R7 program flag cleared", sr_prog_susp, 0);
    busy_n = saved_n;
    resume_op();
    wait_ready();
    chk_eq("R6 erase total time across pause", busy_n, T_EB);
    chk_eq("R6 erase flag cleared", sr_erase_susp, 0);

    // R10 reset during pause aborts
    busy_n = 0;
    issue(2'd0, 3'd1, 4'd0);
    run_cycles(2);
    pause_op();
    chk_eq("R10 paused before reset", sr_erase_susp, 1);
    rst_n = 1'b0;
    #1;
    chk_eq("R10 paused flag cleared by reset", sr_erase_susp, 0);
    chk_eq("R4 rb floats during reset", rb_low, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R10 ready after reset", sr_ready, 1);
    resume_op();
    run_cycles(T_EB + 5);
    chk_eq("R10 no resumed erase", rb_low, 0);

    chk_eq("R1 all expected strobes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule